// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor datapath that reuses a single memory port and a single ALU across several clock cycles per instruction. It is a Moore state machine: each state drives every write enable and multiplexer select of the datapath, and the only input it steers by is the 6-bit opcode field of the instruction register. Every instruction starts with a fetch state and then a decode state in which the register operands are read and a branch target is computed ahead of need. Only after decode does the sequence split by instruction class.

Five classes are recognised: word load, word store, register-to-register ALU operation, branch-if-equal and unconditional jump. Their sequences are 5, 4, 4, 3 and 3 states long. Any other opcode returns to fetch straight after decode. The control outputs and the state code are registers, so the datapath sees glitch-free selects that change only at the clock edge.

Top module: `mc_ctrl_unit`

## Requirements
- R1: While rst is high at a rising edge, the next state is fetch with fetch controls on the outputs; this holds even when reset arrives in the middle of an instruction. State codes on state_o: fetch 0, decode 1, address 2, load-read 3, load-writeback 4, store-write 5, ALU-execute 6, ALU-writeback 7, branch 8, jump 9.
- R2: Fetch drives pc_we_o, mem_rd_o and ir_we_o high, addr_sel_o 0, alu_a_sel_o 0, alu_b_sel_o 01 (constant four), alu_op_o 00 (add) and pc_sel_o 00 (direct ALU result). Every other enable is low. Fetch is always followed by decode.
- R3: Decode drives every write and read enable low (pc_we_o, pc_we_cond_o, mem_rd_o, mem_wr_o, ir_we_o, rf_we_o) with alu_a_sel_o 0, alu_b_sel_o 11 (shifted immediate) and alu_op_o 00.
- R4: A load (opcode 0x23) runs fetch, decode, address, load-read, load-writeback. Address drives alu_a_sel_o 1 and alu_b_sel_o 10. Load-read drives mem_rd_o and addr_sel_o 1. Load-writeback drives rf_we_o and wb_sel_o 1 with rf_dst_o 0.
- R5: A store (opcode 0x2B) runs fetch, decode, address, store-write, then fetch. Store-write drives mem_wr_o and addr_sel_o 1 and never writes the register file.
- R6: An ALU operation (opcode 0x00) runs fetch, decode, ALU-execute, ALU-writeback. Execute drives alu_a_sel_o 1, alu_b_sel_o 00 and alu_op_o 10 (function field). Writeback drives rf_we_o and rf_dst_o 1 with wb_sel_o 0.
- R7: A branch (opcode 0x04) runs fetch, decode, branch. Branch drives pc_we_cond_o, alu_a_sel_o 1, alu_b_sel_o 00, alu_op_o 01 (subtract) and pc_sel_o 01 (registered ALU output).
- R8: A jump (opcode 0x02) runs fetch, decode, jump. Jump drives pc_we_o with pc_sel_o 10 (jump target).
- R9: Any other opcode runs fetch, decode and returns to fetch, with no write enable asserted in either state after fetch.
- R10: mem_rd_o and mem_wr_o are never high together, and pc_we_o and pc_we_cond_o are never high together.
- R11: The sequence load, load, branch, ALU, store takes 21 cycles: 5 fetch states in 21 cycles, with the 22nd cycle a fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | OP_W (6) | Opcode field of the instruction register |
| state_o | output | 4 | Current state code |
| pc_we_o | output | 1 | Unconditional program counter write |
| pc_we_cond_o | output | 1 | Program counter write when ALU result is zero |
| addr_sel_o | output | 1 | Memory address: 0 program counter, 1 ALU output register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_we_o | output | 1 | Instruction register write |
| wb_sel_o | output | 1 | Register write data: 0 ALU output register, 1 memory data register |
| rf_we_o | output | 1 | Register file write |
| rf_dst_o | output | 1 | Destination: 0 second source field, 1 third register field |
| alu_a_sel_o | output | 1 | ALU A: 0 program counter, 1 A register |
| alu_b_sel_o | output | 2 | ALU B: 00 B register, 01 four, 10 immediate, 11 shifted immediate |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 by function field |
| pc_sel_o | output | 2 | 00 ALU result, 01 ALU output register, 10 jump target |

## Verification
The checks take for granted that opcode_i holds steady from the end of fetch until the instruction's last state, as it would when the instruction register is written only in fetch. Decode and the address state sample the opcode, so a change mid-instruction would change the path taken. The bench changes the opcode only while the machine sits in fetch, and it applies reset mid-instruction to cover that entry into fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int ST_W  = 4;
  localparam int SEL_W = 2;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LDRD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STWR   = 4'd5,
    S_EXEC   = 4'd6,
    S_ALUWB  = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9
  } state_t;

  typedef enum logic [2:0] {
    IC_LOAD,
    IC_STORE,
    IC_ALU,
    IC_BRANCH,
    IC_JUMP,
    IC_OTHER
  } iclass_t;

  localparam logic [SEL_W-1:0] BSEL_REG    = 2'd0;
  localparam logic [SEL_W-1:0] BSEL_FOUR   = 2'd1;
  localparam logic [SEL_W-1:0] BSEL_IMM    = 2'd2;
  localparam logic [SEL_W-1:0] BSEL_IMM_SH = 2'd3;

  localparam logic [SEL_W-1:0] AOP_ADD   = 2'd0;
  localparam logic [SEL_W-1:0] AOP_SUB   = 2'd1;
  localparam logic [SEL_W-1:0] AOP_FUNCT = 2'd2;

  localparam logic [SEL_W-1:0] PSEL_ALU = 2'd0;
  localparam logic [SEL_W-1:0] PSEL_OUT = 2'd1;
  localparam logic [SEL_W-1:0] PSEL_JMP = 2'd2;

  typedef struct packed {
    logic             pc_we;
    logic             pc_we_cond;
    logic             addr_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_we;
    logic             wb_sel;
    logic             rf_we;
    logic             rf_dst;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] pc_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OP_W-1:0] OP_ALU    = 6'h00,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'h02
) (
  input  logic [OP_W-1:0] opcode,
  output iclass_t         iclass
);

  always_comb begin
    if (opcode == OP_LOAD)
      iclass = IC_LOAD;
    else if (opcode == OP_STORE)
      iclass = IC_STORE;
    else if (opcode == OP_ALU)
      iclass = IC_ALU;
    else if (opcode == OP_BRANCH)
      iclass = IC_BRANCH;
    else if (opcode == OP_JUMP)
      iclass = IC_JUMP;
    else
      iclass = IC_OTHER;
  end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_t  cur,
  input  iclass_t iclass,
  output state_t  nxt
);

  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (iclass)
          IC_LOAD, IC_STORE: nxt = S_ADDR;
          IC_ALU:            nxt = S_EXEC;
          IC_BRANCH:         nxt = S_BRANCH;
          IC_JUMP:           nxt = S_JUMP;
          default:           nxt = S_FETCH;
        endcase
      end
      S_ADDR: begin
        case (iclass)
          IC_LOAD:  nxt = S_LDRD;
          IC_STORE: nxt = S_STWR;
          default:  nxt = S_FETCH;
        endcase
      end
      S_LDRD:   nxt = S_LDWB;
      S_EXEC:   nxt = S_ALUWB;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_t st,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = CTRL_IDLE;
    case (st)
      S_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_we     = 1'b1;
        ctl.pc_we     = 1'b1;
        ctl.alu_b_sel = BSEL_FOUR;
        ctl.alu_op    = AOP_ADD;
        ctl.pc_sel    = PSEL_ALU;
      end
      S_DECODE: begin
        ctl.alu_b_sel = BSEL_IMM_SH;
        ctl.alu_op    = AOP_ADD;
      end
      S_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_IMM;
        ctl.alu_op    = AOP_ADD;
      end
      S_LDRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      S_STWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      S_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_REG;
        ctl.alu_op    = AOP_FUNCT;
      end
      S_ALUWB: begin
        ctl.rf_we  = 1'b1;
        ctl.rf_dst = 1'b1;
      end
      S_BRANCH: begin
        ctl.pc_we_cond = 1'b1;
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = BSEL_REG;
        ctl.alu_op     = AOP_SUB;
        ctl.pc_sel     = PSEL_OUT;
      end
      S_JUMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_sel = PSEL_JMP;
      end
      default: ctl = CTRL_IDLE;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_unit.sv
module mc_ctrl_unit
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OP_W-1:0] OP_ALU    = 6'h00,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode_i,
  output logic [ST_W-1:0]  state_o,
  output logic             pc_we_o,
  output logic             pc_we_cond_o,
  output logic             addr_sel_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             ir_we_o,
  output logic             wb_sel_o,
  output logic             rf_we_o,
  output logic             rf_dst_o,
  output logic             alu_a_sel_o,
  output logic [SEL_W-1:0] alu_b_sel_o,
  output logic [SEL_W-1:0] alu_op_o,
  output logic [SEL_W-1:0] pc_sel_o
);

  state_t  state_q;
  state_t  state_nx;
  state_t  state_d;
  iclass_t iclass;
  ctrl_t   ctrl_d;
  ctrl_t   ctrl_q;

  mc_op_classify #(
    .OP_W      (OP_W),
    .OP_LOAD   (OP_LOAD),
    .OP_STORE  (OP_STORE),
    .OP_ALU    (OP_ALU),
    .OP_BRANCH (OP_BRANCH),
    .OP_JUMP   (OP_JUMP)
  ) u_classify (
    .opcode (opcode_i),
    .iclass (iclass)
  );

  mc_next_state u_next (
    .cur    (state_q),
    .iclass (iclass),
    .nxt    (state_nx)
  );

  assign state_d = rst ? S_FETCH : state_nx;

  // Controls are decoded from the next state and registered with it,
  // so outputs leave flops in step with state_o.
  mc_ctrl_decode u_decode (
    .st  (state_d),
    .ctl (ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
    ctrl_q  <= ctrl_d;
  end

  assign state_o      = state_q;
  assign pc_we_o      = ctrl_q.pc_we;
  assign pc_we_cond_o = ctrl_q.pc_we_cond;
  assign addr_sel_o   = ctrl_q.addr_sel;
  assign mem_rd_o     = ctrl_q.mem_rd;
  assign mem_wr_o     = ctrl_q.mem_wr;
  assign ir_we_o      = ctrl_q.ir_we;
  assign wb_sel_o     = ctrl_q.wb_sel;
  assign rf_we_o      = ctrl_q.rf_we;
  assign rf_dst_o     = ctrl_q.rf_dst;
  assign alu_a_sel_o  = ctrl_q.alu_a_sel;
  assign alu_b_sel_o  = ctrl_q.alu_b_sel;
  assign alu_op_o     = ctrl_q.alu_op;
  assign pc_sel_o     = ctrl_q.pc_sel;

endmodule

// File: rtl/mc_ctrl_unit_chk.sv
module mc_ctrl_unit_chk #(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OP_W-1:0] OP_ALU    = 6'h00,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'h02
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] opcode_i,
  input logic [3:0]      state_o,
  input logic            pc_we_o,
  input logic            pc_we_cond_o,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic            ir_we_o,
  input logic            rf_we_o,
  input logic            rf_dst_o,
  input logic            wb_sel_o
);

  localparam logic [3:0] C_FETCH  = 4'd0;
  localparam logic [3:0] C_DECODE = 4'd1;
  localparam logic [3:0] C_LDRD   = 4'd3;
  localparam logic [3:0] C_LDWB   = 4'd4;
  localparam logic [3:0] C_STWR   = 4'd5;
  localparam logic [3:0] C_EXEC   = 4'd6;
  localparam logic [3:0] C_ALUWB  = 4'd7;
  localparam logic [3:0] C_BRANCH = 4'd8;
  localparam logic [3:0] C_JUMP   = 4'd9;

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  logic op_known;
  assign op_known = (opcode_i == OP_LOAD) || (opcode_i == OP_STORE) ||
                    (opcode_i == OP_ALU) || (opcode_i == OP_BRANCH) ||
                    (opcode_i == OP_JUMP);

  logic any_write;
  assign any_write = pc_we_o | pc_we_cond_o | mem_wr_o | ir_we_o | rf_we_o | mem_rd_o;

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> state_o == C_FETCH);

  p_fetch_decode_r2: assert property (@(posedge clk) disable iff (rst)
    state_o == C_FETCH |=> state_o == C_DECODE);

  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    state_o == C_DECODE |-> !any_write);

  p_ldwb_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    state_o == C_LDWB |-> ($past(state_o) == C_LDRD && rf_we_o && wb_sel_o));

  p_store_ends_r5: assert property (@(posedge clk) disable iff (rst)
    state_o == C_STWR |=> state_o == C_FETCH);

  p_aluwb_after_exec_r6: assert property (@(posedge clk) disable iff (rst)
    state_o == C_ALUWB |-> ($past(state_o) == C_EXEC && rf_we_o && rf_dst_o));

  p_branch_ends_r7: assert property (@(posedge clk) disable iff (rst)
    state_o == C_BRANCH |=> state_o == C_FETCH);

  p_jump_ends_r8: assert property (@(posedge clk) disable iff (rst)
    state_o == C_JUMP |=> state_o == C_FETCH);

  p_unknown_back_r9: assert property (@(posedge clk) disable iff (rst)
    (state_o == C_DECODE && !op_known) |=> state_o == C_FETCH);

  p_mem_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_o, mem_wr_o}));

  p_pc_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_we_o, pc_we_cond_o}));

endmodule

bind mc_ctrl_unit mc_ctrl_unit_chk #(
  .OP_W      (OP_W),
  .OP_LOAD   (OP_LOAD),
  .OP_STORE  (OP_STORE),
  .OP_ALU    (OP_ALU),
  .OP_BRANCH (OP_BRANCH),
  .OP_JUMP   (OP_JUMP)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .opcode_i     (opcode_i),
  .state_o      (state_o),
  .pc_we_o      (pc_we_o),
  .pc_we_cond_o (pc_we_cond_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .ir_we_o      (ir_we_o),
  .rf_we_o      (rf_we_o),
  .rf_dst_o     (rf_dst_o),
  .wb_sel_o     (wb_sel_o)
);

// File: tb/mc_ctrl_unit_test.sv
module mc_ctrl_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;

  logic [3:0] state_o;
  logic       pc_we_o, pc_we_cond_o, addr_sel_o, mem_rd_o, mem_wr_o, ir_we_o;
  logic       wb_sel_o, rf_we_o, rf_dst_o, alu_a_sel_o;
  logic [1:0] alu_b_sel_o, alu_op_o, pc_sel_o;

  mc_ctrl_unit uut (
    .clk          (clk),
    .rst          (rst),
    .opcode_i     (opcode),
    .state_o      (state_o),
    .pc_we_o      (pc_we_o),
    .pc_we_cond_o (pc_we_cond_o),
    .addr_sel_o   (addr_sel_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .ir_we_o      (ir_we_o),
    .wb_sel_o     (wb_sel_o),
    .rf_we_o      (rf_we_o),
    .rf_dst_o     (rf_dst_o),
    .alu_a_sel_o  (alu_a_sel_o),
    .alu_b_sel_o  (alu_b_sel_o),
    .alu_op_o     (alu_op_o),
    .pc_sel_o     (pc_sel_o)
  );

  always #10 clk = ~clk;   // 50 MHz

  localparam logic [5:0] OPC_LW  = 6'h23;
  localparam logic [5:0] OPC_SW  = 6'h2B;
  localparam logic [5:0] OPC_R   = 6'h00;
  localparam logic [5:0] OPC_BEQ = 6'h04;
  localparam logic [5:0] OPC_J   = 6'h02;

  typedef struct {
    logic [3:0]  st;
    logic [15:0] cv;
    string       req;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int fetch_seen = 0;
  bit finished = 0;

  // Expected control word, bit order:
  // pc_we pc_we_cond addr_sel mem_rd mem_wr ir_we wb_sel rf_we rf_dst alu_a alu_b[2] alu_op[2] pc_sel[2]
  function automatic logic [15:0] exp_ctrl(input logic [3:0] st);
    logic pw = 0, pc = 0, ad = 0, mr = 0, mw = 0, iw = 0, wb = 0, rw = 0, rd = 0, aa = 0;
    logic [1:0] bs = 0, op = 0, ps = 0;
    case (st)
      4'd0: begin pw = 1; mr = 1; iw = 1; bs = 2'b01; end           // R2
      4'd1: begin bs = 2'b11; end                                    // R3
      4'd2: begin aa = 1; bs = 2'b10; end                            // R4
      4'd3: begin mr = 1; ad = 1; end                                // R4
      4'd4: begin rw = 1; wb = 1; end                                // R4
      4'd5: begin mw = 1; ad = 1; end                                // R5
      4'd6: begin aa = 1; op = 2'b10; end                            // R6
      4'd7: begin rw = 1; rd = 1; end                                // R6
      4'd8: begin pc = 1; aa = 1; op = 2'b01; ps = 2'b01; end        // R7
      4'd9: begin pw = 1; ps = 2'b10; end                            // R8
      default: ;
    endcase
    return {pw, pc, ad, mr, mw, iw, wb, rw, rd, aa, bs, op, ps};
  endfunction

  function automatic logic [15:0] act_ctrl();
    return {pc_we_o, pc_we_cond_o, addr_sel_o, mem_rd_o, mem_wr_o, ir_we_o,
            wb_sel_o, rf_we_o, rf_dst_o, alu_a_sel_o, alu_b_sel_o, alu_op_o, pc_sel_o};
  endfunction

  task automatic check_now(input string req, input logic [3:0] est);
    checks++;
    if (state_o !== est || act_ctrl() !== exp_ctrl(est)) begin
      errors++;
      $display("FAIL %s state=%0d ctrl=%h expected state=%0d ctrl=%h",
               req, state_o, act_ctrl(), est, exp_ctrl(est));
    end
  endtask

  task automatic push(input logic [3:0] st, input string req);
    item_t it;
    it.st = st;
    it.cv = exp_ctrl(st);
    it.req = req;
    sb_q.push_back(it);
  endtask

  // Driver: called mid-cycle while the machine is in fetch.
  task automatic run_instr(input logic [5:0] op);
    int n;
    push(4'd0, "R2");
    push(4'd1, "R3");
    case (op)
      OPC_LW:  begin push(4'd2, "R4"); push(4'd3, "R4"); push(4'd4, "R4"); n = 5; end
      OPC_SW:  begin push(4'd2, "R5"); push(4'd5, "R5"); n = 4; end
      OPC_R:   begin push(4'd6, "R6"); push(4'd7, "R6"); n = 4; end
      OPC_BEQ: begin push(4'd8, "R7"); n = 3; end
      OPC_J:   begin push(4'd9, "R8"); n = 3; end
      default: n = 2;
    endcase
    opcode = op;
    repeat (n) @(negedge clk);
    if (n == 2) begin
      #2 check_now("R9", 4'd0);   // unknown opcode back in fetch
    end
  endtask

  // Monitor: samples 5 ns after each falling edge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (!rst) begin
        if (state_o == 4'd0) fetch_seen++;
        if (sb_q.size() > 0) begin
          it = sb_q.pop_front();
          checks++;
          if (state_o !== it.st || act_ctrl() !== it.cv) begin
            errors++;
            $display("FAIL %s state=%0d ctrl=%h expected state=%0d ctrl=%h",
                     it.req, state_o, act_ctrl(), it.st, it.cv);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    #2 check_now("R1", 4'd0);   // reset state
    rst = 1'b0;

    // each class on its own
    run_instr(OPC_LW);
    run_instr(OPC_SW);
    run_instr(OPC_R);
    run_instr(OPC_BEQ);
    run_instr(OPC_J);
    run_instr(6'h3F);
    run_instr(OPC_R);
    run_instr(6'h08);
    run_instr(OPC_J);

    // R1: reset in the middle of a load, in the address state
    push(4'd0, "R2");
    push(4'd1, "R3");
    opcode = OPC_LW;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #2 check_now("R1", 4'd0);
    rst = 1'b0;
    run_instr(OPC_BEQ);

    // R11: five-instruction program, 21 cycles
    f0 = fetch_seen;
    run_instr(OPC_LW);
    run_instr(OPC_LW);
    run_instr(OPC_BEQ);
    run_instr(OPC_R);
    run_instr(OPC_SW);
    checks++;
    if (fetch_seen - f0 != 5) begin
      errors++;
      $display("FAIL R11 fetches in 21 cycles=%0d expected 5", fetch_seen - f0);
    end
    #2 check_now("R11", 4'd0);

    run_instr(OPC_J);
    repeat (2) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard left=%0d expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule